// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block is the home node of a distributed shared-memory system. For every memory block it owns, it keeps a directory entry. The entry holds a coherence state (Uncached, Shared or Exclusive) and a presence vector with one bit per processor. Requesting nodes send read misses, write misses and write-backs. The controller answers each one with explicit point-to-point messages and does not broadcast. These messages are data replies, invalidations to sharers, fetch requests to the current owner, and acknowledgements.

Requests arrive on a valid/ready port and carry a kind, the requesting node and a block address. Outgoing messages leave on a second valid/ready port and carry a kind, a target node and the block address. When a block is held exclusively by another node, the controller sends a fetch to that owner. It then waits for the owner's flush on a one-bit response handshake and only then answers the requester. The controller serves one transaction at a time. Network routing and the data storage lie outside the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory entry is Uncached with an empty presence vector. `reqReady` is 1, `outValid` is 0 and `rspReady` is 0.
- R2: A read miss (`reqType` 0) to an Uncached or Shared block produces exactly one data reply (`outType` 0) to the requester. The requester is added to the sharers, and the entry becomes or stays Shared.
- R3: A write miss (`reqType` 1) to a Shared block that has sharers other than the requester first sends one invalidation (`outType` 1) to each of those sharers, in ascending node order. It then sends a data reply to the requester. The entry becomes Exclusive with only the requester present.
- R4: A write miss to an Uncached block, or to a Shared block whose only sharer is the requester, sends only a data reply and leaves the entry Exclusive to the requester.
- R5: A read or write miss to a block held Exclusive by another node sends a fetch (`outType` 2) to the owner. The controller then waits with `rspReady` high until `rspValid` arrives, and only then sends the data reply. After a read the entry is Shared with the owner and the requester present. After a write it is Exclusive to the requester.
- R6: A read or write miss from the node that already owns an Exclusive block sends the data reply with no fetch. A read leaves the entry Shared with that node only.
- R7: A write-back (`reqType` 2) from the owner of an Exclusive block is answered with an acknowledgement (`outType` 3) and leaves the entry Uncached. Some requests are still acknowledged but leave the entry unchanged: a write-back from any other node, a write-back to a block that is not Exclusive, and the reserved code 3.
- R8: From the acceptance of a request until the handshake of its final message, `reqReady` is 0. `rspReady` is 1 only while a fetch response is awaited, and `rspValid` has no effect at any other time.
- R9: The first message of a transaction is valid in the cycle after the request is accepted. The data reply that follows a fetch is valid in the cycle after the response is accepted.
- R10: While `outValid` is 1 and `outReady` is 0, the message kind, node and address hold steady.
- R11: Entries for different addresses are independent, and every message carries the address of the request it serves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqType | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 reserved |
| reqNode | input | NODE_W (2) | Requesting node |
| reqAddr | input | ADDR_W (3) | Block address |
| rspValid | input | 1 | Owner's flush in reply to a fetch |
| rspReady | output | 1 | Controller is waiting for a fetch response |
| outValid | output | 1 | Outgoing message present |
| outReady | input | 1 | Network takes the outgoing message |
| outType | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 acknowledge |
| outNode | output | NODE_W (2) | Target node of the message |
| outAddr | output | ADDR_W (3) | Block address of the message |

## Verification
Each transaction puts its first message on the port exactly one cycle after the request handshake. Invalidations then follow one per cycle while `outReady` is high. A data reply after a fetch is due one cycle after the response handshake, and `reqReady` returns in the cycle after the final message handshake. The bench drives inputs and samples outputs at falling edges, so each sample lands in the cycle where the count of registers on the path says the value is due. It checks the first-message and post-response latencies explicitly on every transaction. Directory state is observed only through the messages that later requests produce.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SHR = 2'd1,
    DIR_EXC = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    REQ_RD  = 2'd0,
    REQ_WR  = 2'd1,
    REQ_WB  = 2'd2,
    REQ_RSV = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    MSG_DATA  = 2'd0,
    MSG_INV   = 2'd1,
    MSG_FETCH = 2'd2,
    MSG_ACK   = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    F_IDLE  = 3'd0,
    F_INV   = 3'd1,
    F_FETCH = 3'd2,
    F_WAIT  = 3'd3,
    F_REPLY = 3'd4
  } fsm_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      accept;   // latch request and snapshot its entry
    logic      invPop;   // drop lowest pending sharer
    logic      commit;   // write the new entry
    msg_kind_e kind;     // kind of message currently offered
  } ctrl_strobe_t;

endpackage

// File: rtl/dir_home_dp.sv
module dir_home_dp
  import dir_pkg::*;
#(
  parameter int NUM_NODES  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int NODE_W     = $clog2(NUM_NODES),
  parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [1:0]        reqType,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [ADDR_W-1:0] reqAddr,
  output dir_state_e        inState,
  output logic              inOthers,
  output logic              inOwnerIsReq,
  output logic              pendLast,
  output logic              curIsMiss,
  output logic [1:0]        outType,
  output logic [NODE_W-1:0] outNode,
  output logic [ADDR_W-1:0] outAddr
);

  function automatic logic [NODE_W-1:0] lowestIdx(input logic [NUM_NODES-1:0] v);
    lowestIdx = '0;
    for (int i = NUM_NODES - 1; i >= 0; i--) begin
      if (v[i]) lowestIdx = NODE_W'(i);
    end
  endfunction

  function automatic logic [NUM_NODES-1:0] nodeBit(input logic [NODE_W-1:0] n);
    nodeBit = '0;
    nodeBit[n] = 1'b1;
  endfunction

  // directory storage
  dir_state_e           stArr  [NUM_BLOCKS];
  logic [NUM_NODES-1:0] vecArr [NUM_BLOCKS];

  // latched transaction
  req_kind_e            curType;
  logic [NODE_W-1:0]    curNode;
  logic [ADDR_W-1:0]    curAddr;
  logic [NODE_W-1:0]    ownerIdx;
  logic [NUM_NODES-1:0] pending;

  // lookup for the incoming request
  logic [NUM_NODES-1:0] inVec;
  logic [NUM_NODES-1:0] inBit;

  assign inVec        = vecArr[reqAddr];
  assign inState      = stArr[reqAddr];
  assign inBit        = nodeBit(reqNode);
  assign inOthers     = |(inVec & ~inBit);
  assign inOwnerIsReq = (inVec == inBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curType  <= REQ_RD;
      curNode  <= '0;
      curAddr  <= '0;
      ownerIdx <= '0;
      pending  <= '0;
    end else if (strobe.accept) begin
      curType  <= req_kind_e'(reqType);
      curNode  <= reqNode;
      curAddr  <= reqAddr;
      ownerIdx <= lowestIdx(inVec);
      pending  <= inVec & ~inBit;
    end else if (strobe.invPop) begin
      pending  <= pending & ~nodeBit(lowestIdx(pending));
    end
  end

  assign pendLast  = ((pending & (pending - 1'b1)) == '0);
  assign curIsMiss = (curType == REQ_RD) || (curType == REQ_WR);

  // next directory entry for the latched transaction
  dir_state_e           curState, nextSt;
  logic [NUM_NODES-1:0] curVec, nextVec, curBit;

  assign curState = stArr[curAddr];
  assign curVec   = vecArr[curAddr];
  assign curBit   = nodeBit(curNode);

  always_comb begin
    nextSt  = curState;
    nextVec = curVec;
    unique case (curType)
      REQ_RD: begin
        nextSt  = DIR_SHR;
        nextVec = curVec | curBit;
      end
      REQ_WR: begin
        nextSt  = DIR_EXC;
        nextVec = curBit;
      end
      REQ_WB: begin
        if (curState == DIR_EXC && curVec == curBit) begin
          nextSt  = DIR_UNC;
          nextVec = '0;
        end
      end
      default: ;
    endcase
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_entry
    dir_state_e           entSt;
    logic [NUM_NODES-1:0] entVec;
    logic                 wrEn;

    assign wrEn = strobe.commit && (curAddr == ADDR_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entSt  <= DIR_UNC;
        entVec <= '0;
      end else if (wrEn) begin
        entSt  <= nextSt;
        entVec <= nextVec;
      end
    end

    assign stArr[b]  = entSt;
    assign vecArr[b] = entVec;
  end

  // outgoing message fields
  always_comb begin
    unique case (strobe.kind)
      MSG_INV:   outNode = lowestIdx(pending);
      MSG_FETCH: outNode = ownerIdx;
      default:   outNode = curNode;
    endcase
  end

  assign outType = strobe.kind;
  assign outAddr = curAddr;

endmodule

// File: rtl/dir_home_fsm.sv
module dir_home_fsm
  import dir_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   reqType,
  input  logic         rspValid,
  input  logic         outReady,
  input  dir_state_e   inState,
  input  logic         inOthers,
  input  logic         inOwnerIsReq,
  input  logic         pendLast,
  input  logic         curIsMiss,
  output ctrl_strobe_t strobe,
  output logic         reqReady,
  output logic         rspReady,
  output logic         outValid
);

  fsm_e state, stateNext;
  logic isRead, isWrite, accept;

  assign isRead  = (req_kind_e'(reqType) == REQ_RD);
  assign isWrite = (req_kind_e'(reqType) == REQ_WR);

  assign reqReady = (state == F_IDLE);
  assign rspReady = (state == F_WAIT);
  assign outValid = (state == F_INV) || (state == F_FETCH) || (state == F_REPLY);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      F_IDLE: begin
        if (accept) begin
          if ((isRead || isWrite) && inState == DIR_EXC && !inOwnerIsReq)
            stateNext = F_FETCH;
          else if (isWrite && inState == DIR_SHR && inOthers)
            stateNext = F_INV;
          else
            stateNext = F_REPLY;
        end
      end
      F_INV:   if (outReady && pendLast) stateNext = F_REPLY;
      F_FETCH: if (outReady) stateNext = F_WAIT;
      F_WAIT:  if (rspValid) stateNext = F_REPLY;
      F_REPLY: if (outReady) stateNext = F_IDLE;
      default: stateNext = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= F_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe        = '0;
    strobe.kind   = MSG_DATA;
    strobe.accept = accept;
    unique case (state)
      F_INV: begin
        strobe.kind   = MSG_INV;
        strobe.invPop = outReady;
      end
      F_FETCH: strobe.kind = MSG_FETCH;
      F_REPLY: begin
        strobe.kind   = curIsMiss ? MSG_DATA : MSG_ACK;
        strobe.commit = outReady;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_NODES  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int NODE_W     = $clog2(NUM_NODES),
  parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqType,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              rspValid,
  output logic              rspReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outType,
  output logic [NODE_W-1:0] outNode,
  output logic [ADDR_W-1:0] outAddr
);

  ctrl_strobe_t strobe;
  dir_state_e   inState;
  logic         inOthers, inOwnerIsReq, pendLast, curIsMiss;

  dir_home_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqType      (reqType),
    .rspValid     (rspValid),
    .outReady     (outReady),
    .inState      (inState),
    .inOthers     (inOthers),
    .inOwnerIsReq (inOwnerIsReq),
    .pendLast     (pendLast),
    .curIsMiss    (curIsMiss),
    .strobe       (strobe),
    .reqReady     (reqReady),
    .rspReady     (rspReady),
    .outValid     (outValid)
  );

  dir_home_dp #(
    .NUM_NODES  (NUM_NODES),
    .NUM_BLOCKS (NUM_BLOCKS),
    .NODE_W     (NODE_W),
    .ADDR_W     (ADDR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqType      (reqType),
    .reqNode      (reqNode),
    .reqAddr      (reqAddr),
    .inState      (inState),
    .inOthers     (inOthers),
    .inOwnerIsReq (inOwnerIsReq),
    .pendLast     (pendLast),
    .curIsMiss    (curIsMiss),
    .outType      (outType),
    .outNode      (outNode),
    .outAddr      (outAddr)
  );

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NODE_W = 2,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqType,
  input logic              rspValid,
  input logic              rspReady,
  input logic              outValid,
  input logic              outReady,
  input logic [1:0]        outType,
  input logic [NODE_W-1:0] outNode,
  input logic [ADDR_W-1:0] outAddr
);

  // R8: an idle controller offers no message and awaits no response
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!outValid && !rspReady));

  // R8: no new request is taken while a fetch response is awaited
  p_wait_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> !reqReady);

  // R9: first message follows acceptance by one cycle
  p_first_msg_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> outValid);

  // R5: accepted fetch leads to waiting for the owner
  p_fetch_waits_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outType == 2'd2) |=> rspReady);

  // R9: data reply follows the owner's response by one cycle
  p_reply_after_rsp_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady) |=> (outValid && outType == 2'd0));

  // R7: a write-back is answered by an acknowledgement
  p_wb_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqType == 2'd2) |=> (outValid && outType == 2'd3));

  // R10: a stalled message holds steady
  p_hold_msg_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      (outValid && $stable(outType) && $stable(outNode) && $stable(outAddr)));

endmodule

bind dir_home_ctrl dir_home_chk #(
  .NODE_W (NODE_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqType  (reqType),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .outValid (outValid),
  .outReady (outReady),
  .outType  (outType),
  .outNode  (outNode),
  .outAddr  (outAddr)
);

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [1:0] reqType = 2'd0;
  logic [1:0] reqNode = 2'd0;
  logic [2:0] reqAddr = 3'd0;
  logic       rspValid = 1'b0;
  logic       rspReady;
  logic       outValid;
  logic       outReady = 1'b1;
  logic [1:0] outType;
  logic [1:0] outNode;
  logic [2:0] outAddr;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  dir_home_ctrl u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqType  (reqType),
    .reqNode  (reqNode),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .outValid (outValid),
    .outReady (outReady),
    .outType  (outType),
    .outNode  (outNode),
    .outAddr  (outAddr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // row: tag[29:26] type[25:24] node[23:22] addr[21:19] count[18:16] msgs[15:0]
  // each message nibble is {outType, outNode}
  localparam int NROWS = 23;
  localparam logic [29:0] ROWS [NROWS] = '{
    {4'd2,  2'd0, 2'd0, 3'd1, 3'd1, 16'h0000}, // R2 read, uncached
    {4'd2,  2'd0, 2'd2, 3'd1, 3'd1, 16'h2000}, // R2 read, shared
    {4'd2,  2'd0, 2'd3, 3'd1, 3'd1, 16'h3000}, // R2 read, shared
    {4'd3,  2'd1, 2'd2, 3'd1, 3'd3, 16'h4720}, // R3 inval 0 and 3
    {4'd5,  2'd0, 2'd1, 3'd1, 3'd2, 16'hA100}, // R5 read from owner 2
    {4'd3,  2'd1, 2'd1, 3'd1, 3'd2, 16'h6100}, // R3 inval 2
    {4'd5,  2'd1, 2'd3, 3'd1, 3'd2, 16'h9300}, // R5 write, fetch owner 1
    {4'd7,  2'd2, 2'd0, 3'd1, 3'd1, 16'hC000}, // R7 wb from non-owner
    {4'd5,  2'd0, 2'd0, 3'd1, 3'd2, 16'hB000}, // R5 owner still 3
    {4'd7,  2'd2, 2'd3, 3'd1, 3'd1, 16'hF000}, // R7 wb in shared
    {4'd3,  2'd1, 2'd0, 3'd1, 3'd2, 16'h7000}, // R3 sharer 3 kept
    {4'd6,  2'd0, 2'd0, 3'd1, 3'd1, 16'h0000}, // R6 owner read
    {4'd4,  2'd1, 2'd0, 3'd1, 3'd1, 16'h0000}, // R4 sole sharer writes
    {4'd6,  2'd1, 2'd0, 3'd1, 3'd1, 16'h0000}, // R6 owner write
    {4'd7,  2'd2, 2'd0, 3'd1, 3'd1, 16'hC000}, // R7 owner wb
    {4'd4,  2'd1, 2'd2, 3'd1, 3'd1, 16'h2000}, // R4 write, uncached
    {4'd11, 2'd1, 2'd1, 3'd5, 3'd1, 16'h1000}, // R11 other block
    {4'd11, 2'd0, 2'd3, 3'd1, 3'd2, 16'hA300}, // R11 block 1 untouched
    {4'd7,  2'd3, 2'd1, 3'd5, 3'd1, 16'hD000}, // R7 reserved code
    {4'd7,  2'd0, 2'd0, 3'd5, 3'd2, 16'h9000}, // R7 owner 1 kept
    {4'd11, 2'd1, 2'd3, 3'd7, 3'd1, 16'h3000}, // R11 top address
    {4'd5,  2'd0, 2'd0, 3'd7, 3'd2, 16'hB000}, // R5 fetch at top address
    {4'd3,  2'd1, 2'd1, 3'd1, 3'd3, 16'h6710}  // R3 ascending order 2,3
  };

  task automatic runTxn(input logic [1:0] t, input logic [1:0] nd, input logic [2:0] ad,
                        output int cnt, output logic [15:0] got);
    int  guard;
    bit  done;
    cnt  = 0;
    got  = '0;
    done = 1'b0;
    reqType  = t;
    reqNode  = nd;
    reqAddr  = ad;
    reqValid = 1'b1;
    guard = 0;
    while (!reqReady && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    reqValid = 1'b0;
    check(outValid == 1'b1, "R9", "first message one cycle after accept", outValid, 1);
    guard = 0;
    while (!done && guard < 40) begin
      guard++;
      if (outValid) begin
        check(outAddr == ad, "R11", "message address", outAddr, ad);
        if (cnt < 4) got[15 - 4*cnt -: 4] = {outType, outNode};
        cnt++;
        if (outType == 2'd0 || outType == 2'd3) done = 1'b1;
        if (outType == 2'd2) begin
          @(negedge clk);
          check(rspReady && !reqReady && !outValid, "R8", "wait flags {rsp,req,out}",
                {rspReady, reqReady, outValid}, 3'b100);
          @(negedge clk);
          check(rspReady && !outValid, "R5", "hold until response {rsp,out}",
                {rspReady, outValid}, 2'b10);
          rspValid = 1'b1;
          @(negedge clk);
          rspValid = 1'b0;
          check(outValid && outType == 2'd0, "R9", "reply after response {valid,type}",
                {outValid, outType}, 3'b100);
        end else begin
          @(negedge clk);
        end
      end else begin
        @(negedge clk);
      end
    end
    check(reqReady == 1'b1, "R8", "ready after final message", reqReady, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    int          cnt;
    logic [15:0] got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(rspReady == 1'b0, "R1", "rspReady after reset", rspReady, 0);

    // R8 response pulse while idle is ignored
    rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0;
    check(!outValid && reqReady && !rspReady, "R8", "idle rsp ignored {out,req,rsp}",
          {outValid, reqReady, rspReady}, 3'b010);

    for (int i = 0; i < NROWS; i++) begin
      runTxn(ROWS[i][25:24], ROWS[i][23:22], ROWS[i][21:19], cnt, got);
      check(cnt == int'(ROWS[i][18:16]), $sformatf("R%0d", ROWS[i][29:26]),
            $sformatf("row %0d message count", i), cnt, ROWS[i][18:16]);
      check(got == ROWS[i][15:0], $sformatf("R%0d", ROWS[i][29:26]),
            $sformatf("row %0d messages", i), got, ROWS[i][15:0]);
    end

    // R10 backpressure on a reply; R1 block 3 still uncached
    outReady = 1'b0;
    reqType  = 2'd0;
    reqNode  = 2'd1;
    reqAddr  = 3'd3;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(outValid && outType == 2'd0 && outNode == 2'd1 && outAddr == 3'd3, "R10",
            "stalled reply {valid,type,node,addr}",
            {outValid, outType, outNode, outAddr}, {1'b1, 2'd0, 2'd1, 3'd3});
      check(!reqReady, "R8", "busy while stalled", reqReady, 0);
      @(negedge clk);
    end
    outReady = 1'b1;
    @(negedge clk);
    check(!outValid && reqReady, "R10", "released {out,req}", {outValid, reqReady}, 2'b01);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule